// File: doc/BRIEF.md
# Direct-Mapped Read Cache with Line Refill and Retry

This block is a read-only, direct-mapped cache that serves one side of a processor, either instruction fetch or data load. Each request carries two candidate word addresses, the program counter and the ALU result, and a select input picks which one is looked up. When the selected address hits, the requested word appears on the response port in the same cycle the request is accepted.

When the lookup misses, the block latches the address, lowers its ready output and asks the memory side for the whole line. The line is requested at its aligned base address, and the memory returns sixteen words, one per valid beat. After the last word is written, the line's valid bit is set and the lookup is run again. That retried lookup is an ordinary hit, and it is the only point at which the response for a missed request is produced. No word is forwarded early. Default sizing gives 16 KB: 256 lines of sixteen 32-bit words.

The controller has four states. IDLE accepts requests and answers hits directly. FILL_REQ holds a line request until memory accepts it. FILL_WAIT writes one word per valid beat. RETRY repeats the lookup. The transitions are: IDLE to FILL_REQ on a miss; FILL_REQ to FILL_WAIT on memory acceptance; FILL_WAIT to RETRY on the sixteenth beat; RETRY to IDLE on the hit. RETRY would return to FILL_REQ if the retried lookup missed.

Top module: `refill_cache`

## Requirements
- R1: After reset every line is invalid, so the first access to any address misses. Out of reset, req_ready is 1 while rsp_valid and mem_req_valid are 0.
- R2: src_sel = 0 looks up pc_addr and src_sel = 1 looks up alu_addr. The address that is not selected has no effect on hit or miss.
- R3: A request accepted in IDLE that hits raises rsp_valid in the same cycle. rsp_data is then the stored word, and no memory request is issued.
- R4: Address bits [5:2] pick one of 16 words in the line, bits [13:6] pick one of 256 lines, and bits [31:14] form the tag. Lines with different indexes are held independently.
- R5: On a miss, mem_req_valid rises with mem_req_addr equal to the request address with bits [5:0] cleared. Both stay unchanged until mem_req_ready is seen high.
- R6: During the fill, exactly one word is written per cycle with mem_rsp_valid high, in ascending word order, for 16 beats. Idle cycles between beats are tolerated.
- R7: The line becomes valid only with its 16th word. The response for a missed request comes from the retried lookup after all 16 beats and carries the word at the requested offset.
- R8: From the cycle after a miss is accepted until its response, req_ready stays 0 and no new request is taken.
- R9: A miss to a line index already holding another tag replaces that line, so the earlier address misses again.
- R10: Address bits [1:0] are ignored when the word is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request |
| src_sel | input | 1 | 0 selects pc_addr, 1 selects alu_addr |
| pc_addr | input | 32 | Program-counter byte address |
| alu_addr | input | 32 | ALU-result byte address |
| req_ready | output | 1 | High when a request can be accepted |
| rsp_valid | output | 1 | Requested word is on rsp_data |
| rsp_data | output | 32 | Returned word |
| mem_req_valid | output | 1 | Line fill request to memory |
| mem_req_addr | output | 32 | Line-aligned fill address |
| mem_req_ready | input | 1 | Memory accepts the fill request |
| mem_rsp_valid | input | 1 | Fill word beat |
| mem_rsp_data | input | 32 | Fill word |

## Verification
Lookups are driven through both address sources, and the unselected source is loaded with a conflicting address, so a wrong multiplexer choice turns a hit into a miss or the reverse. Hits to several word offsets, and to nonzero byte offsets, within one filled line separate correct offset slicing from a fixed word. Two fill patterns are applied: back-to-back beats with immediate request acceptance, and beats with idle gaps after a delayed acceptance. Together they show whether words are written only on valid beats and whether the response waits for the sixteenth one. Finally, a conflicting tag at the same index, followed by a return to the first address, distinguishes real replacement from a tag compare that ignores bits.

// File: rtl/refill_cache_pkg.sv
package refill_cache_pkg;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_FILL_REQ  = 2'd1,
        ST_FILL_WAIT = 2'd2,
        ST_RETRY     = 2'd3
    } fill_state_t;

endpackage

// File: rtl/rc_tag_store.sv
module rc_tag_store #(
    parameter int NUM_LINES = 256,
    parameter int TAG_W     = 18,
    localparam int IDX_W    = $clog2(NUM_LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic [TAG_W-1:0] rd_tag,
    output logic             hit,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag
);

    logic [NUM_LINES-1:0] valid_q;
    logic [TAG_W-1:0]     tag_q [NUM_LINES];

    // Valid bits clear on reset; a line turns valid only with its tag write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx] <= wr_tag;
        end
    end

    always_comb begin
        hit = valid_q[rd_idx] && (tag_q[rd_idx] == rd_tag);
    end

    // A freshly written line must report a hit for the tag just stored
    assert_line_valid_after_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> valid_q[$past(wr_idx)]);

endmodule

// File: rtl/rc_data_store.sv
module rc_data_store #(
    parameter int NUM_LINES  = 256,
    parameter int LINE_WORDS = 16,
    parameter int WORD_W     = 32,
    localparam int IDX_W     = $clog2(NUM_LINES),
    localparam int OFF_W     = $clog2(LINE_WORDS),
    localparam int DEPTH     = NUM_LINES * LINE_WORDS
) (
    input  logic              clk,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [OFF_W-1:0]  rd_off,
    output logic [WORD_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [OFF_W-1:0]  wr_off,
    input  logic [WORD_W-1:0] wr_data
);

    logic [WORD_W-1:0] word_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            word_q[{wr_idx, wr_off}] <= wr_data;
        end
    end

    always_comb begin
        rd_data = word_q[{rd_idx, rd_off}];
    end

endmodule

// File: rtl/rc_fill_ctrl.sv
module rc_fill_ctrl
    import refill_cache_pkg::*;
#(
    parameter int LINE_WORDS = 16,
    localparam int OFF_W     = $clog2(LINE_WORDS),
    localparam logic [OFF_W-1:0] LAST_BEAT = OFF_W'(LINE_WORDS - 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             lookup_hit,
    input  logic             mem_req_ready,
    input  logic             mem_rsp_valid,
    output fill_state_t      state,
    output logic [OFF_W-1:0] beat_cnt,
    output logic             req_ready,
    output logic             rsp_valid,
    output logic             mem_req_valid,
    output logic             capture,
    output logic             fill_we,
    output logic             fill_last
);

    fill_state_t nxt_state;

    // State register and beat counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            beat_cnt <= '0;
        end else begin
            state <= nxt_state;
            if (state == ST_FILL_REQ) begin
                beat_cnt <= '0;
            end else if (fill_we) begin
                beat_cnt <= beat_cnt + 1'b1;
            end
        end
    end

    // Next state and outputs
    always_comb begin
        nxt_state     = state;
        req_ready     = 1'b0;
        rsp_valid     = 1'b0;
        mem_req_valid = 1'b0;
        capture       = 1'b0;
        fill_we       = 1'b0;
        fill_last     = 1'b0;
        unique case (state)
            ST_IDLE: begin
                req_ready = 1'b1;
                if (req_valid) begin
                    if (lookup_hit) begin
                        rsp_valid = 1'b1;
                    end else begin
                        capture   = 1'b1;
                        nxt_state = ST_FILL_REQ;
                    end
                end
            end
            ST_FILL_REQ: begin
                mem_req_valid = 1'b1;
                if (mem_req_ready) begin
                    nxt_state = ST_FILL_WAIT;
                end
            end
            ST_FILL_WAIT: begin
                if (mem_rsp_valid) begin
                    fill_we = 1'b1;
                    if (beat_cnt == LAST_BEAT) begin
                        fill_last = 1'b1;
                        nxt_state = ST_RETRY;
                    end
                end
            end
            ST_RETRY: begin
                if (lookup_hit) begin
                    rsp_valid = 1'b1;
                    nxt_state = ST_IDLE;
                end else begin
                    nxt_state = ST_FILL_REQ;
                end
            end
            default: nxt_state = ST_IDLE;
        endcase
    end

    // A held request stays asserted until memory accepts it
    assert_req_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> mem_req_valid);

    // Once a miss is captured, no new request is taken
    assert_ready_low_after_miss_R8: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> !req_ready);

    // No response while line words are still arriving
    assert_no_rsp_during_fill_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FILL_WAIT) |-> !rsp_valid);

    // The final beat leads straight to the retried lookup
    assert_retry_after_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fill_last |=> (state == ST_RETRY));

endmodule

// File: rtl/refill_cache.sv
module refill_cache
    import refill_cache_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int WORD_W     = 32,
    parameter int LINE_WORDS = 16,
    parameter int NUM_LINES  = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              src_sel,
    input  logic [ADDR_W-1:0] pc_addr,
    input  logic [ADDR_W-1:0] alu_addr,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [WORD_W-1:0] rsp_data,
    output logic              mem_req_valid,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_req_ready,
    input  logic              mem_rsp_valid,
    input  logic [WORD_W-1:0] mem_rsp_data
);

    localparam int BOFF_W = $clog2(WORD_W / 8);
    localparam int OFF_W  = $clog2(LINE_WORDS);
    localparam int IDX_W  = $clog2(NUM_LINES);
    localparam int TAG_W  = ADDR_W - IDX_W - OFF_W - BOFF_W;
    localparam int IDX_LO = BOFF_W + OFF_W;
    localparam int TAG_LO = IDX_LO + IDX_W;

    fill_state_t       state;
    logic [OFF_W-1:0]  beat_cnt;
    logic              lookup_hit;
    logic              capture;
    logic              fill_we;
    logic              fill_last;
    logic              rsp_valid_int;
    logic [ADDR_W-1:0] sel_addr;
    logic [ADDR_W-1:0] miss_addr_q;
    logic [ADDR_W-1:0] look_addr;
    logic [WORD_W-1:0] rd_word;

    // Address source multiplexer and lookup address
    always_comb begin
        sel_addr  = src_sel ? alu_addr : pc_addr;
        look_addr = (state == ST_IDLE) ? sel_addr : miss_addr_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            miss_addr_q <= '0;
        end else if (capture) begin
            miss_addr_q <= sel_addr;
        end
    end

    rc_tag_store #(
        .NUM_LINES(NUM_LINES),
        .TAG_W    (TAG_W)
    ) u_tags (
        .clk   (clk),
        .rst_n (rst_n),
        .rd_idx(look_addr[TAG_LO-1:IDX_LO]),
        .rd_tag(look_addr[ADDR_W-1:TAG_LO]),
        .hit   (lookup_hit),
        .wr_en (fill_last),
        .wr_idx(miss_addr_q[TAG_LO-1:IDX_LO]),
        .wr_tag(miss_addr_q[ADDR_W-1:TAG_LO])
    );

    rc_data_store #(
        .NUM_LINES (NUM_LINES),
        .LINE_WORDS(LINE_WORDS),
        .WORD_W    (WORD_W)
    ) u_data (
        .clk    (clk),
        .rd_idx (look_addr[TAG_LO-1:IDX_LO]),
        .rd_off (look_addr[IDX_LO-1:BOFF_W]),
        .rd_data(rd_word),
        .wr_en  (fill_we),
        .wr_idx (miss_addr_q[TAG_LO-1:IDX_LO]),
        .wr_off (beat_cnt),
        .wr_data(mem_rsp_data)
    );

    rc_fill_ctrl #(
        .LINE_WORDS(LINE_WORDS)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .lookup_hit   (lookup_hit),
        .mem_req_ready(mem_req_ready),
        .mem_rsp_valid(mem_rsp_valid),
        .state        (state),
        .beat_cnt     (beat_cnt),
        .req_ready    (req_ready),
        .rsp_valid    (rsp_valid_int),
        .mem_req_valid(mem_req_valid),
        .capture      (capture),
        .fill_we      (fill_we),
        .fill_last    (fill_last)
    );

    always_comb begin
        rsp_valid    = rsp_valid_int;
        rsp_data     = rsp_valid_int ? rd_word : '0;
        mem_req_addr = {miss_addr_q[ADDR_W-1:IDX_LO], {IDX_LO{1'b0}}};
    end

    // The fill address must not move while memory has not accepted it
    assert_fill_addr_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> $stable(mem_req_addr));

    // After a complete fill, the repeated lookup must hit
    assert_retry_hits_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RETRY) |-> lookup_hit);

    // A response is never produced while a fill request is pending
    assert_no_rsp_with_fill_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !rsp_valid);

endmodule

// File: tb/tb_refill_cache.sv
module tb_refill_cache;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic        src_sel;
    logic [31:0] pc_addr;
    logic [31:0] alu_addr;
    logic        req_ready;
    logic        rsp_valid;
    logic [31:0] rsp_data;
    logic        mem_req_valid;
    logic [31:0] mem_req_addr;
    logic        mem_req_ready;
    logic        mem_rsp_valid;
    logic [31:0] mem_rsp_data;

    int n_checks = 0;
    int n_fail   = 0;

    // memory model state
    int          n_reqs      = 0;
    int          beats_total = 0;
    int          beats_left  = 0;
    int          beat_idx    = 0;
    int          acc_wait    = 0;
    int          req_delay   = 0;
    bit          gap_en      = 1'b0;
    bit          gap_phase   = 1'b0;
    bit          armed       = 1'b0;
    logic [31:0] fill_base   = '0;
    logic [31:0] last_base   = '0;

    always #4 clk = ~clk;

    refill_cache dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .src_sel      (src_sel),
        .pc_addr      (pc_addr),
        .alu_addr     (alu_addr),
        .req_ready    (req_ready),
        .rsp_valid    (rsp_valid),
        .rsp_data     (rsp_data),
        .mem_req_valid(mem_req_valid),
        .mem_req_addr (mem_req_addr),
        .mem_req_ready(mem_req_ready),
        .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data (mem_rsp_data)
    );

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        logic [31:0] w;
        w = {a[31:2], 2'b00};
        return (w * 32'h9E3779B1) ^ 32'h13572468;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    // Behavioural line-fill memory
    task automatic mem_model();
        forever begin
            @(negedge clk);
            if (armed) begin
                armed         = 1'b0;
                mem_req_ready = 1'b0;
                beats_left    = 16;
                beat_idx      = 0;
                gap_phase     = 1'b0;
                last_base     = fill_base;
                n_reqs++;
            end
            mem_rsp_valid = 1'b0;
            if (beats_left > 0) begin
                if (gap_en && gap_phase) begin
                    gap_phase = 1'b0;
                end else begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = mem_word(fill_base + 32'(beat_idx * 4));
                    beat_idx++;
                    beats_left--;
                    beats_total++;
                    gap_phase = 1'b1;
                end
            end
            if (mem_req_valid && !mem_req_ready && !armed) begin
                if (acc_wait >= req_delay) begin
                    acc_wait      = 0;
                    mem_req_ready = 1'b1;
                    fill_base     = mem_req_addr;
                    armed         = 1'b1;
                end else begin
                    acc_wait++;
                end
            end
        end
    endtask

    // One lookup; expect_hit selects the check sequence
    task automatic access(input bit sel, input logic [31:0] addr, input logic [31:0] other,
                          input bit expect_hit, input string req);
        int  reqs0;
        int  beats0;
        bit  ready_low;
        bit  got;
        @(negedge clk);
        req_valid = 1'b1;
        src_sel   = sel;
        pc_addr   = sel ? other : addr;
        alu_addr  = sel ? addr : other;
        #1;
        reqs0  = n_reqs;
        beats0 = beats_total;
        if (expect_hit) begin
            check(rsp_valid === 1'b1, req, "hit response same cycle", 32'(rsp_valid), 32'd1);
            check(rsp_data === mem_word(addr), req, "hit data", rsp_data, mem_word(addr));
            @(posedge clk);
            #1;
            req_valid = 1'b0;
            check(mem_req_valid === 1'b0 && req_ready === 1'b1, req, "no fill after hit",
                  32'(mem_req_valid), 32'd0);
        end else begin
            check(rsp_valid === 1'b0, req, "miss gives no immediate response",
                  32'(rsp_valid), 32'd0);
            @(posedge clk);
            #1;
            req_valid = 1'b0;
            ready_low = 1'b1;
            got       = 1'b0;
            for (int i = 0; i < 300 && !got; i++) begin
                @(negedge clk);
                #1;
                if (rsp_valid === 1'b1) got = 1'b1;
                else if (req_ready !== 1'b0) ready_low = 1'b0;
            end
            check(got, req, "response after refill", 32'(got), 32'd1);
            check(ready_low, "R8", "ready low while miss outstanding", 32'(ready_low), 32'd1);
            check(rsp_data === mem_word(addr), "R7", "retried word", rsp_data, mem_word(addr));
            check(beats_total - beats0 == 16, "R6", "beats consumed before response",
                  32'(beats_total - beats0), 32'd16);
            check(n_reqs - reqs0 == 1, "R5", "single fill request", 32'(n_reqs - reqs0), 32'd1);
            check(last_base === {addr[31:6], 6'd0}, "R5", "aligned fill address",
                  last_base, {addr[31:6], 6'd0});
            @(posedge clk);
            #1;
            check(req_ready === 1'b1 && rsp_valid === 1'b0, "R7", "back to idle after retry",
                  32'(req_ready), 32'd1);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(req_ready === 1'b1, "R1", "ready after reset", 32'(req_ready), 32'd1);
        check(rsp_valid === 1'b0, "R1", "no response after reset", 32'(rsp_valid), 32'd0);
        check(mem_req_valid === 1'b0, "R1", "no fill after reset", 32'(mem_req_valid), 32'd0);
    endtask

    task automatic t_cold_miss();
        access(1'b0, 32'h0000_1248, 32'h0000_1248, 1'b0, "R1");
    endtask

    task automatic t_word_select();
        access(1'b1, 32'h0000_1240, 32'h0ABC_0000, 1'b1, "R4");
        access(1'b1, 32'h0000_127C, 32'h0ABC_0000, 1'b1, "R4");
        access(1'b0, 32'h0000_125C, 32'h0ABC_0000, 1'b1, "R3");
    endtask

    task automatic t_byte_offset();
        access(1'b0, 32'h0000_1263, 32'h0000_0000, 1'b1, "R10");
        access(1'b1, 32'h0000_1251, 32'h0000_0000, 1'b1, "R10");
    endtask

    task automatic t_src_select();
        // selected source cached, other not: must hit (R2)
        access(1'b0, 32'h0000_1244, 32'h7777_7700, 1'b1, "R2");
        // selected source uncached, other cached: must miss (R2)
        access(1'b1, 32'h0002_0304, 32'h0000_1244, 1'b0, "R2");
    endtask

    task automatic t_gapped_fill();
        gap_en    = 1'b1;
        req_delay = 3;
        access(1'b0, 32'h0005_0A38, 32'h0, 1'b0, "R6");
        access(1'b0, 32'h0005_0A00, 32'h0, 1'b1, "R6");
        access(1'b1, 32'h0005_0A3C, 32'h0, 1'b1, "R6");
        gap_en    = 1'b0;
        req_delay = 0;
    endtask

    task automatic t_conflict();
        // same index as 0x1240 (index 0x49), different tag
        access(1'b0, 32'h0040_1250, 32'h0, 1'b0, "R9");
        access(1'b0, 32'h0040_1240, 32'h0, 1'b1, "R9");
        access(1'b1, 32'h0000_1250, 32'h0, 1'b0, "R9");
    endtask

    task automatic t_independent_lines();
        access(1'b0, 32'h0002_0300, 32'h0, 1'b1, "R4");
        access(1'b1, 32'h0005_0A10, 32'h0, 1'b1, "R4");
        access(1'b0, 32'h0000_1278, 32'h0, 1'b1, "R4");
    endtask

    initial begin
        rst_n         = 1'b0;
        req_valid     = 1'b0;
        src_sel       = 1'b0;
        pc_addr       = '0;
        alu_addr      = '0;
        mem_req_ready = 1'b0;
        mem_rsp_valid = 1'b0;
        mem_rsp_data  = '0;
        repeat (4) @(posedge clk);
        #1;
        rst_n = 1'b1;
        fork
            mem_model();
        join_none
        t_reset();
        t_cold_miss();
        t_word_select();
        t_byte_offset();
        t_src_select();
        t_gapped_fill();
        t_conflict();
        t_independent_lines();
        repeat (4) @(posedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd1, 32'd0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule